// File: doc/BRIEF.md
# Load Store-Wait Predictor

This block remembers which loads have been caught reading memory ahead of an older store to the same address. It keeps a table of 1024 one-bit entries, indexed by the load's instruction address. When the pipeline reports a memory-ordering violation, the entry for the offending load is set. When a load is fetched, its entry is looked up, and the resulting wait flag travels with the load into the issue queue.

A small gate turns each stored wait flag into an issue permission. A flagged load may not issue while any older store is still unresolved. An unflagged load is never held back. Once a flag is set it would stay set for good, so an internal timer wipes the whole table at a fixed interval and lets the predictor learn again.

The block is used at the fetch stage for lookup, at the retire or violation-detect stage for training, and at issue select for permission. Violation detection, the issue queue itself and fetch sequencing are outside the block.

Top module: `ldw_predictor`

## Requirements
- R1: The table index is instruction-address bits [11:2]. Addresses that differ only in bits [1:0] or in bits above 11 share an entry.
- R2: A violation report (`viol_vld` high) sets the entry addressed by `viol_pc`.
- R3: A lookup (`fetch_vld` high) presents its result one clock later: `fetch_wait_vld` is 1 and `fetch_wait` holds the entry's value. In a cycle after no lookup, both outputs are 0.
- R4: A lookup and a violation report in the same cycle return the entry's value from before that cycle's update, even when both use the same index.
- R5: Synchronous reset clears every entry and drives `fetch_wait_vld` and `fetch_wait` to 0.
- R6: The whole table is cleared on every CLEAR_PERIOD-th rising edge after reset is released. The first clear falls on edge number CLEAR_PERIOD.
- R7: A periodic clear wins over a violation report on the same edge, so the reported entry ends up 0. A lookup on that edge still returns the value from before the clear.
- R8: `issue_ok` is 0 exactly when `iq_wait` and `older_st_pend` are both 1. Otherwise it is 1, and it responds combinationally.
- R9: Setting one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Lookup request for a fetched load |
| fetch_pc | input | PC_W | Address of the fetched load |
| viol_vld | input | 1 | Ordering-violation report |
| viol_pc | input | PC_W | Address of the violating load |
| fetch_wait_vld | output | 1 | Lookup result valid (one cycle after request) |
| fetch_wait | output | 1 | Predicted wait flag for the looked-up load |
| iq_wait | input | 1 | Wait flag of the load being considered for issue |
| older_st_pend | input | 1 | Some older store is still outstanding |
| issue_ok | output | 1 | Load may issue |

## Verification
The assertions check the following on every cycle: a reported violation is present in the table one edge later, a lookup result always follows its request with the entry's pre-update value, the timer never runs past its period and its clear pulse lasts one cycle, and a flagged load is never permitted while a store is pending. Only the bench's scenarios can show the address slicing and aliasing, the exact edge on which the periodic wipe lands, the wipe winning over a simultaneous training event, and retraining after a wipe. These depend on the external address patterns and on absolute cycle counts.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
  localparam int unsigned DEF_PC_W      = 32;
  localparam int unsigned DEF_IDX_W     = 10;
  localparam int unsigned DEF_ALIGN_W   = 2;
  localparam int unsigned DEF_CLR_CYCLE = 16384;
endpackage

// File: rtl/ldw_index.sv
module ldw_index #(
  parameter int unsigned PC_W    = ldw_pkg::DEF_PC_W,
  parameter int unsigned IDX_W   = ldw_pkg::DEF_IDX_W,
  parameter int unsigned ALIGN_W = ldw_pkg::DEF_ALIGN_W
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned HI = ALIGN_W + IDX_W;

  assign idx_o = pc_i[HI-1:ALIGN_W];

  // bits outside the index window deliberately play no part
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[PC_W-1:HI], pc_i[ALIGN_W-1:0]};
endmodule

// File: rtl/ldw_clear_timer.sv
module ldw_clear_timer #(
  parameter int unsigned PERIOD = ldw_pkg::DEF_CLR_CYCLE
) (
  input  logic clk,
  input  logic rst,
  output logic clr_o
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign clr_o = (cnt_q == LAST);

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R6
  clr_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    clr_o |=> !clr_o);
endmodule

// File: rtl/ldw_table.sv
module ldw_table #(
  parameter int unsigned IDX_W = ldw_pkg::DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe_i,
  input  logic             set_vld_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic             rd_bit_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst || wipe_i)   bits_q <= '0;
    else if (set_vld_i)  bits_q[set_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_o <= 1'b0;
      rd_bit_o <= 1'b0;
    end else begin
      rd_vld_o <= rd_en_i;
      rd_bit_o <= rd_en_i & bits_q[rd_idx_i];
    end
  end

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vld_i && !wipe_i) |=> bits_q[$past(set_idx_i)]);

  // R4
  read_old_value_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> (rd_vld_o && (rd_bit_o == $past(bits_q[rd_idx_i]))));

  // R7
  wipe_empties_chk: assert property (@(posedge clk) disable iff (rst)
    wipe_i |=> (bits_q == '0));
endmodule

// File: rtl/ldw_issue_gate.sv
module ldw_issue_gate (
  input  logic wait_i,
  input  logic st_pend_i,
  output logic ok_o
);
  assign ok_o = ~(wait_i & st_pend_i);

  // R8
  always_comb begin
    flagged_hold_chk: assert (!(wait_i && st_pend_i && ok_o));
  end
endmodule

// File: rtl/ldw_predictor.sv
module ldw_predictor #(
  parameter int unsigned PC_W         = ldw_pkg::DEF_PC_W,
  parameter int unsigned IDX_W        = ldw_pkg::DEF_IDX_W,
  parameter int unsigned ALIGN_W      = ldw_pkg::DEF_ALIGN_W,
  parameter int unsigned CLEAR_PERIOD = ldw_pkg::DEF_CLR_CYCLE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_vld,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            viol_vld,
  input  logic [PC_W-1:0] viol_pc,
  output logic            fetch_wait_vld,
  output logic            fetch_wait,
  input  logic            iq_wait,
  input  logic            older_st_pend,
  output logic            issue_ok
);
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] set_idx;
  logic             wipe;

  ldw_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_rd_idx (
    .pc_i (fetch_pc),
    .idx_o(rd_idx)
  );

  ldw_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) u_set_idx (
    .pc_i (viol_pc),
    .idx_o(set_idx)
  );

  ldw_clear_timer #(.PERIOD(CLEAR_PERIOD)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr_o(wipe)
  );

  ldw_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wipe_i   (wipe),
    .set_vld_i(viol_vld),
    .set_idx_i(set_idx),
    .rd_en_i  (fetch_vld),
    .rd_idx_i (rd_idx),
    .rd_vld_o (fetch_wait_vld),
    .rd_bit_o (fetch_wait)
  );

  ldw_issue_gate u_gate (
    .wait_i   (iq_wait),
    .st_pend_i(older_st_pend),
    .ok_o     (issue_ok)
  );

  // R3
  no_req_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_vld |=> (!fetch_wait_vld && !fetch_wait));
endmodule

// File: tb/test_ldw_predictor.sv
module test_ldw_predictor;
  localparam int unsigned P = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_vld = 1'b0, viol_vld = 1'b0, iq_wait = 1'b0, older_st_pend = 1'b0;
  logic [31:0] fetch_pc = '0, viol_pc = '0;
  logic fetch_wait_vld, fetch_wait, issue_ok;

  int checks = 0, fails = 0, edges = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ldw_predictor #(.CLEAR_PERIOD(P)) i_ldw_predictor (
    .clk(clk), .rst(rst),
    .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .viol_vld(viol_vld), .viol_pc(viol_pc),
    .fetch_wait_vld(fetch_wait_vld), .fetch_wait(fetch_wait),
    .iq_wait(iq_wait), .older_st_pend(older_st_pend), .issue_ok(issue_ok)
  );

  typedef struct packed {
    logic        vv;
    logic [31:0] vpc;
    logic        fv;
    logic [31:0] fpc;
    logic        ev;
    logic        ew;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 32'h0,     1'b1, 32'h100,  1'b1, 1'b0}, // R5 empty after reset
    '{1'b1, 32'h100,   1'b1, 32'h100,  1'b1, 1'b0}, // R4 same-cycle returns old
    '{1'b0, 32'h0,     1'b1, 32'h100,  1'b1, 1'b1}, // R2 set seen
    '{1'b0, 32'h0,     1'b1, 32'h104,  1'b1, 1'b0}, // R9 neighbour untouched
    '{1'b0, 32'h0,     1'b1, 32'h1100, 1'b1, 1'b1}, // R1 high bits alias
    '{1'b1, 32'h3,     1'b1, 32'h0,    1'b1, 1'b0}, // R4 index 0, old
    '{1'b0, 32'h0,     1'b1, 32'h0,    1'b1, 1'b1}, // R1 low bits ignored
    '{1'b1, 32'h104,   1'b0, 32'h0,    1'b0, 1'b0}, // R3 no request
    '{1'b0, 32'h0,     1'b1, 32'h104,  1'b1, 1'b1}, // R2 second entry
    '{1'b0, 32'h0,     1'b1, 32'hFFC,  1'b1, 1'b0}, // R9 top entry clear
    '{1'b1, 32'hFFC,   1'b0, 32'h0,    1'b0, 1'b0}, // R3 set top
    '{1'b0, 32'h0,     1'b1, 32'hFFC,  1'b1, 1'b1}  // R2 top entry set
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    edges++;
  endtask

  task automatic drive(input logic vv, input logic [31:0] vpc,
                       input logic fv, input logic [31:0] fpc);
    viol_vld = vv; viol_pc = vpc; fetch_vld = fv; fetch_pc = fpc;
  endtask

  task automatic lookup(input string req, input logic [31:0] pc, input logic exp);
    drive(1'b0, 0, 1'b1, pc);
    tick();
    chk(req, fetch_wait_vld, 1'b1);
    chk(req, fetch_wait, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(1'b0, 0, 1'b0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    edges = 0;
  endtask

  initial begin
    do_reset();
    chk("R5 valid", fetch_wait_vld, 1'b0);
    chk("R5 wait", fetch_wait, 1'b0);

    for (int i = 0; i < 12; i++) begin
      drive(VECS[i].vv, VECS[i].vpc, VECS[i].fv, VECS[i].fpc);
      tick();
      chk("R3 vld", fetch_wait_vld, VECS[i].ev);
      chk("R1/R2/R4/R9 wait", fetch_wait, VECS[i].ew);
    end
    drive(1'b0, 0, 1'b0, 0);

    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < 2; s++) begin
        iq_wait = w[0]; older_st_pend = s[0];
        #1;
        chk("R8 issue_ok", issue_ok, !(w[0] && s[0]));
      end
    end
    iq_wait = 1'b0; older_st_pend = 1'b0;

    // periodic wipe: lands on edge P
    while (edges < P - 2) tick();
    lookup("R6 before wipe", 32'h100, 1'b1);          // edge P-1
    drive(1'b1, 32'h200, 1'b1, 32'h100);
    tick();                                            // edge P: wipe + set
    chk("R7 read before wipe", fetch_wait, 1'b1);
    lookup("R6 wiped", 32'h100, 1'b0);
    lookup("R7 wipe beats set", 32'h200, 1'b0);
    lookup("R6 top wiped", 32'hFFC, 1'b0);

    drive(1'b1, 32'h104, 1'b0, 0);
    tick();
    lookup("R2 retrain", 32'h104, 1'b1);

    // second wipe at edge 2P
    while (edges < 2 * P - 1) tick();
    lookup("R6 before second wipe", 32'h104, 1'b1);    // edge 2P
    lookup("R6 second wipe", 32'h104, 1'b0);

    // reset in mid-run
    drive(1'b1, 32'h300, 1'b0, 0);
    tick();
    do_reset();
    lookup("R5 table cleared", 32'h300, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule